// File: doc/BRIEF.md
# Four-Mode Directed Rounding Unit

This block takes a sign-magnitude operand whose magnitude has already been cut to the target fraction width. The bits below that width are folded into a guard bit and a sticky bit. The block decides whether the kept magnitude must be bumped by one unit in the last place, and that decision depends on the selected rounding mode and on the operand's sign. It returns the rounded magnitude, a carry-out flag and an inexact flag.

Directed modes act on the signed value. Rounding toward minus infinity therefore grows the magnitude of a negative number and leaves a positive one alone, and rounding toward plus infinity does the opposite. Round-to-nearest resolves an exact half by picking the candidate whose last kept bit is 0.

When the bump overflows the kept field, the carry-out tells the surrounding datapath to adjust its exponent, and the returned magnitude is zero. The result is registered, so it appears one clock after the operand is presented with `in_valid`. Normalisation, exponent arithmetic and special values belong to the caller.

Top module: `rnd_unit`

## Requirements
- R1: In mode 2'b00 (nearest), a discarded part below one half (guard=0) keeps the magnitude, and a part above one half (guard=1, sticky=1) adds one to it.
- R2: In mode 2'b00, an exact half (guard=1, sticky=0) adds one only when the kept LSB is 1, so the result's LSB is 0.
- R3: In mode 2'b01 (toward minus infinity), a negative operand (sign=1) with any nonzero discarded bit is incremented in magnitude, and a positive operand keeps its magnitude.
- R4: In mode 2'b10 (toward plus infinity), a positive operand (sign=0) with any nonzero discarded bit is incremented in magnitude, and a negative operand keeps its magnitude.
- R5: In mode 2'b11 (toward zero), the magnitude is never changed and carry-out stays 0, for every guard, sticky and sign value.
- R6: The inexact flag equals guard OR sticky in every mode.
- R7: When an increment is applied to an all-ones magnitude, carry-out is 1 and the returned magnitude is all zeros.
- R8: A result appears on the outputs, with out_valid high, exactly one clock after in_valid is sampled high. out_valid is low in every other cycle, and reset clears out_valid, out_mag, out_carry and out_inexact to 0.
- R9: An exact operand (guard=0, sticky=0) comes back unchanged with carry-out 0 and inexact 0 in every mode and for both signs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present this cycle |
| in_sign | input | 1 | Operand sign, 1 = negative |
| in_mag | input | INT_W+FRAC_W | Kept magnitude, integer bits above fraction bits |
| in_guard | input | 1 | First discarded bit |
| in_sticky | input | 1 | OR of all discarded bits below the guard bit |
| in_mode | input | 2 | 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero |
| out_valid | output | 1 | Result valid |
| out_mag | output | INT_W+FRAC_W | Rounded magnitude |
| out_carry | output | 1 | Increment overflowed the kept field |
| out_inexact | output | 1 | Some discarded bit was nonzero |

## Verification
The worked value 1.011 with a single half bit behind it is rounded in all four modes at both signs. This shows that the directed modes respond to the sign and that nearest mode resolves the tie to an even LSB. Below-half, above-half and exact-half discarded parts on even and odd magnitudes separate the nearest-mode tie rule from plain half-up rounding. An all-ones magnitude forced to increment shows the carry path. An exhaustive sweep of every magnitude, guard, sticky, sign and mode of the small bench configuration, with idle gaps between bursts, compares each result against a model built on the signed value and checks the one-cycle timing.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

    typedef enum logic [1:0] {
        RND_NEAR_EVEN = 2'b00,
        RND_TO_NEG    = 2'b01,
        RND_TO_POS    = 2'b10,
        RND_TO_ZERO   = 2'b11
    } rnd_mode_e;

endpackage

// File: rtl/rnd_bump_decide.sv
module rnd_bump_decide
    import rnd_pkg::*;
(
    input  logic      sign,
    input  logic      lsb,
    input  logic      guard,
    input  logic      sticky,
    input  rnd_mode_e mode,
    output logic      bump,
    output logic      lost
);
    logic below_any;
    logic half_or_more_odd;

    always_comb begin
        below_any        = guard | sticky;
        half_or_more_odd = guard & (sticky | lsb);
        lost             = below_any;
        unique case (mode)
            RND_NEAR_EVEN: bump = half_or_more_odd;
            RND_TO_NEG:    bump = sign & below_any;
            RND_TO_POS:    bump = ~sign & below_any;
            default:       bump = 1'b0;
        endcase
    end

endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic         inc,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] chain;

    assign chain[0] = inc;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]     = a[i] ^ chain[i];
        assign chain[i+1] = a[i] & chain[i];
    end

    assign cout = chain[W];

endmodule

// File: rtl/rnd_unit.sv
module rnd_unit
    import rnd_pkg::*;
#(
    parameter int INT_W  = 4,
    parameter int FRAC_W = 8,
    localparam int MAG_W = INT_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sign,
    input  logic [MAG_W-1:0] in_mag,
    input  logic             in_guard,
    input  logic             in_sticky,
    input  logic [1:0]       in_mode,
    output logic             out_valid,
    output logic [MAG_W-1:0] out_mag,
    output logic             out_carry,
    output logic             out_inexact
);
    typedef struct packed {
        logic             vld;
        logic [MAG_W-1:0] mag;
        logic             carry;
        logic             inexact;
    } rnd_state_t;

    rnd_state_t st_d, st_q;

    logic             bump;
    logic             lost;
    logic [MAG_W-1:0] sum;
    logic             cout;
    rnd_mode_e        mode_e;

    assign mode_e = rnd_mode_e'(in_mode);

    rnd_bump_decide u_decide (
        .sign   (in_sign),
        .lsb    (in_mag[0]),
        .guard  (in_guard),
        .sticky (in_sticky),
        .mode   (mode_e),
        .bump   (bump),
        .lost   (lost)
    );

    rnd_incr #(.W(MAG_W)) u_incr (
        .a    (in_mag),
        .inc  (bump),
        .sum  (sum),
        .cout (cout)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.mag     = sum;
            st_d.carry   = cout;
            st_d.inexact = lost;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.vld;
    assign out_mag     = st_q.mag;
    assign out_carry   = st_q.carry;
    assign out_inexact = st_q.inexact;

endmodule

// File: rtl/rnd_unit_chk.sv
module rnd_unit_chk #(
    parameter int MAG_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_sign,
    input logic [MAG_W-1:0] in_mag,
    input logic             in_guard,
    input logic             in_sticky,
    input logic [1:0]       in_mode,
    input logic             out_valid,
    input logic [MAG_W-1:0] out_mag,
    input logic             out_carry,
    input logic             out_inexact
);
    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_inexact_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_inexact == ($past(in_guard) | $past(in_sticky))));

    assert_exact_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_guard && !in_sticky) |=>
            (out_mag == $past(in_mag) && !out_carry && !out_inexact));

    assert_truncate_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'b11) |=> (out_mag == $past(in_mag) && !out_carry));

    assert_carry_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_carry) |-> (out_mag == '0));

    assert_step_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_carry || out_mag == $past(in_mag)
                      || out_mag == MAG_W'($past(in_mag) + 1'b1)));

endmodule

bind rnd_unit rnd_unit_chk #(.MAG_W(MAG_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_sign     (in_sign),
    .in_mag      (in_mag),
    .in_guard    (in_guard),
    .in_sticky   (in_sticky),
    .in_mode     (in_mode),
    .out_valid   (out_valid),
    .out_mag     (out_mag),
    .out_carry   (out_carry),
    .out_inexact (out_inexact)
);

// File: tb/rnd_unit_tb_top.sv
module rnd_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int INT_W  = 2;
    localparam int FRAC_W = 3;
    localparam int MAG_W  = INT_W + FRAC_W;
    localparam int WATCHDOG = 20000;

    typedef struct {
        logic [MAG_W-1:0] mag;
        logic             carry;
        logic             inexact;
        string            req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_sign = 1'b0;
    logic [MAG_W-1:0] in_mag = '0;
    logic             in_guard = 1'b0;
    logic             in_sticky = 1'b0;
    logic [1:0]       in_mode = 2'b00;
    logic             out_valid;
    logic [MAG_W-1:0] out_mag;
    logic             out_carry;
    logic             out_inexact;

    int   n_checks = 0;
    int   n_fails  = 0;
    exp_t sb_q[$];
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rnd_unit #(.INT_W(INT_W), .FRAC_W(FRAC_W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_sign     (in_sign),
        .in_mag      (in_mag),
        .in_guard    (in_guard),
        .in_sticky   (in_sticky),
        .in_mode     (in_mode),
        .out_valid   (out_valid),
        .out_mag     (out_mag),
        .out_carry   (out_carry),
        .out_inexact (out_inexact)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Model on the signed value: the discarded part is graded as
    // 0 exact, 1 below half, 2 exactly half, 3 above half.
    function automatic exp_t model(input logic s, input logic [MAG_W-1:0] m,
                                   input logic g, input logic st,
                                   input logic [1:0] md, input string req);
        exp_t e;
        int   grade;
        int   up;
        int   total;
        grade = (g ? 2 : 0) + (st ? 1 : 0);
        case (md)
            2'b00: up = (grade == 3 || (grade == 2 && m[0])) ? 1 : 0;
            2'b01: up = (s && grade != 0) ? 1 : 0;
            2'b10: up = (!s && grade != 0) ? 1 : 0;
            default: up = 0;
        endcase
        total     = int'(m) + up;
        e.carry   = (total >= (1 << MAG_W));
        e.mag     = MAG_W'(total % (1 << MAG_W));
        e.inexact = (grade != 0);
        e.req     = req;
        return e;
    endfunction

    task automatic drive(input logic s, input logic [MAG_W-1:0] m, input logic g,
                         input logic st, input logic [1:0] md, input string req);
        @(negedge clk);
        in_valid  = 1'b1;
        in_sign   = s;
        in_mag    = m;
        in_guard  = g;
        in_sticky = st;
        in_mode   = md;
        sb_q.push_back(model(s, m, g, st, md, req));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: pops one expected item per valid output, flags stray outputs (R8).
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R8", "out_valid with nothing pending", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(out_mag == e.mag, e.req, "magnitude", int'(out_mag), int'(e.mag));
                check(out_carry == e.carry, e.req, "carry", int'(out_carry), int'(e.carry));
                check(out_inexact == e.inexact, e.req, "inexact",
                      int'(out_inexact), int'(e.inexact));
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            check(1'b0, "R8", "watchdog expired", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check(out_valid == 1'b0, "R8", "reset out_valid", int'(out_valid), 0);
        check(out_mag == '0, "R8", "reset out_mag", int'(out_mag), 0);
        check(out_carry == 1'b0, "R8", "reset out_carry", int'(out_carry), 0);
        check(out_inexact == 1'b0, "R8", "reset out_inexact", int'(out_inexact), 0);
        rst_n = 1'b1;
        idle(2);

        // Worked value 1.011 with half bit behind it (mag 5'b01011 = 11)
        drive(1'b0, 5'd11, 1'b1, 1'b0, 2'b00, "R2");  // -> 12
        drive(1'b0, 5'd11, 1'b1, 1'b0, 2'b01, "R3");  // -> 11
        drive(1'b0, 5'd11, 1'b1, 1'b0, 2'b10, "R4");  // -> 12
        drive(1'b0, 5'd11, 1'b1, 1'b0, 2'b11, "R5");  // -> 11
        drive(1'b1, 5'd11, 1'b1, 1'b0, 2'b00, "R2");  // -> 12
        drive(1'b1, 5'd11, 1'b1, 1'b0, 2'b01, "R3");  // -> 12
        drive(1'b1, 5'd11, 1'b1, 1'b0, 2'b10, "R4");  // -> 11
        drive(1'b1, 5'd11, 1'b1, 1'b0, 2'b11, "R5");  // -> 11
        idle(1);
        // Nearest: even tie stays, below keeps, above bumps
        drive(1'b0, 5'd10, 1'b1, 1'b0, 2'b00, "R2");  // -> 10
        drive(1'b0, 5'd10, 1'b0, 1'b1, 2'b00, "R1");  // -> 10 inexact
        drive(1'b0, 5'd10, 1'b1, 1'b1, 2'b00, "R1");  // -> 11
        drive(1'b1, 5'd13, 1'b0, 1'b1, 2'b00, "R1");  // -> 13
        // Exact operands
        drive(1'b0, 5'd7, 1'b0, 1'b0, 2'b10, "R9");
        drive(1'b1, 5'd7, 1'b0, 1'b0, 2'b01, "R9");
        // Sticky alone drives directed modes and inexact
        drive(1'b1, 5'd4, 1'b0, 1'b1, 2'b01, "R6");   // -> 5
        drive(1'b0, 5'd4, 1'b0, 1'b1, 2'b01, "R6");   // -> 4
        idle(3);
        // Overflow of the kept field
        drive(1'b0, 5'd31, 1'b1, 1'b1, 2'b00, "R7");
        drive(1'b0, 5'd31, 1'b0, 1'b1, 2'b10, "R7");
        drive(1'b1, 5'd31, 1'b1, 1'b0, 2'b01, "R7");
        drive(1'b1, 5'd31, 1'b1, 1'b1, 2'b11, "R5");
        idle(2);

        // Exhaustive sweep with an idle gap after each magnitude
        for (int m = 0; m < (1 << MAG_W); m++) begin
            for (int md = 0; md < 4; md++) begin
                for (int b = 0; b < 8; b++) begin
                    drive(b[2], MAG_W'(m), b[1], b[0], 2'(md), "R1");
                end
            end
            idle(1 + (m % 3));
        end
        idle(3);

        // R8: every presented operand produced exactly one result
        check(sb_q.size() == 0, "R8", "results still pending", sb_q.size(), 0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule